// File: doc/BRIEF.md
# Three-Channel Compare Timer

This block is a 16-bit up-counter with three compare channels. Each channel owns a compare register and one output pin. When the counter equals a channel's register on a cycle where the counter advances, the channel applies its programmed action to its pin: hold, drive low, drive high or invert. The same event sets that channel's sticky match flag. Compare register A can also reset the counter, which makes the counter a period generator for the other two channels.

The counter advances on a one-cycle count-source pulse `tick` while the start bit is set. A small run controller has three states. **IDLE**: the start bit is clear and counting is off. **RUN**: counting is on. **HALT**: counting stopped after a match with A while the continue bit was clear. The transitions are: *go* (IDLE to RUN when start is set), *pause* (RUN to IDLE when start is cleared), *stop_on_a* (RUN or IDLE to HALT on an A match with the continue bit clear), and *release* (HALT to IDLE when start is cleared). Software configures the block through a write port with an 8-bit address and 16-bit data. Reads are combinational from `addr`.

Register map (16-bit, even addresses): 0x00 control (bit0 start, bit1 continue, bits 4:2 counter-clear select); 0x02 counter; 0x04/0x06/0x08 compare A/B/C; 0x0A action codes (4 bits per channel, A at 3:0, B at 7:4, C at 11:8); 0x0C pin setup (bits 2:0 initial levels, bits 6:4 pin disables); 0x0E match flags (bits 2:0).

Top module: `tmr_cmp3`

## Requirements
- R1: After reset the counter reads 0, all flags are 0, all pins are low, every compare register reads 16'hFFFF, and control, action codes and pin setup read 0.
- R2: On a clock edge with `tick`=1, start=1, the controller not in HALT and no counter write, the counter advances by one, unless R3 applies. With `tick`=0 it holds.
- R3: With clear select 3'b001, an advancing cycle whose counter value equals compare A loads 0 into the counter instead of the value plus one. The sequence is m, 0, 1.
- R4: With continue=0, an A match enters HALT: the counter and pins then hold despite ticks. Clearing start and then setting it again resumes from the held value.
- R5: While start=0, the counter and the pins hold their values whatever `tick` does.
- R6: On a match, a channel applies the action given by the two low bits of its code: 00 hold, 01 low, 10 high, 11 invert. The upper code bits are ignored, so 4'b1001 drives low. The change is visible after the edge that sees the match.
- R7: A write to the counter loads each channel's output with its initial-level bit (0 low, 1 high). That cycle applies no compare action and does not advance the counter.
- R8: A match sets its flag, and the flag stays 1 until a flag-register write with 0 in that bit. Writing 1 leaves the flag unchanged. A match in the same cycle as a clearing write leaves the flag at 1.
- R9: A pin-disable bit of 1 holds that pin low. With 0 the pin shows the channel output.
- R10: Every register reads back what was last written to its fields, and unused bits read 0.
- R11: With clear select 3'b000 the counter wraps from 16'hFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count-source enable pulse |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data for `addr` |
| pin_o | output | 3 | Compare output pins, bit 0 is channel A |
| flag_o | output | 3 | Sticky match flags, bit 0 is channel A |

## Verification
The assertions check on every cycle the counter's step, clear-to-zero and hold rules, the frozen counter in HALT, output stability without a match, inversion on a match, and flag stickiness including match-over-clear. The ordering effects can only be shown by the bench's scenarios against its reference model: the exact cycle on which a pin changes relative to a tick, the reloading of initial levels on a counter write, resume after HALT, wrap at the top of the range, and register readback.

// File: rtl/tmr_cmp3_pkg.sv
package tmr_cmp3_pkg;
    // register offsets
    localparam int ADR_CTRL  = 'h00;
    localparam int ADR_COUNT = 'h02;
    localparam int ADR_CMP0  = 'h04;
    localparam int ADR_ACT   = 'h0A;
    localparam int ADR_PINS  = 'h0C;
    localparam int ADR_FLAG  = 'h0E;
    localparam int CODE_W    = 4;     // action code width per channel
    localparam int DIS_LSB   = 4;     // first pin-disable bit in pin setup

    localparam logic [2:0] CLR_ON_A = 3'b001;

    typedef enum logic [1:0] {
        ACT_KEEP = 2'b00,
        ACT_LOW  = 2'b01,
        ACT_HIGH = 2'b10,
        ACT_FLIP = 2'b11
    } act_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } run_e;

    typedef struct packed {
        logic [2:0] clr_sel;
        logic       cont;
        logic       start;
    } ctrl_t;
endpackage

// File: rtl/tc_regs.sv
module tc_regs import tmr_cmp3_pkg::*; #(
    parameter int AW  = 8,
    parameter int DW  = 16,
    parameter int CW  = 16,
    parameter int NCH = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [AW-1:0]                 addr,
    input  logic [DW-1:0]                 wdata,
    input  logic [NCH-1:0]                hit,
    input  logic [CW-1:0]                 cnt,
    output ctrl_t                         ctrl,
    output logic [NCH-1:0][CW-1:0]        cmp,
    output logic [NCH-1:0][CODE_W-1:0]    code,
    output logic [NCH-1:0]                init,
    output logic [NCH-1:0]                dis,
    output logic [NCH-1:0]                flag,
    output logic                          cnt_wr,
    output logic [CW-1:0]                 cnt_wval,
    output logic [DW-1:0]                 rdata
);
    logic wr_ctrl, wr_act, wr_pins, wr_flag;

    assign wr_ctrl  = wr_en && (addr == AW'(ADR_CTRL));
    assign cnt_wr   = wr_en && (addr == AW'(ADR_COUNT));
    assign wr_act   = wr_en && (addr == AW'(ADR_ACT));
    assign wr_pins  = wr_en && (addr == AW'(ADR_PINS));
    assign wr_flag  = wr_en && (addr == AW'(ADR_FLAG));
    assign cnt_wval = wdata[CW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0;
            code <= '0;
            init <= '0;
            dis  <= '0;
        end else begin
            if (wr_ctrl) ctrl <= ctrl_t'(wdata[$bits(ctrl_t)-1:0]);
            if (wr_act)  code <= wdata[NCH*CODE_W-1:0];
            if (wr_pins) begin
                init <= wdata[NCH-1:0];
                dis  <= wdata[DIS_LSB +: NCH];
            end
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_cmp
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cmp[i] <= '1;
            else if (wr_en && (addr == AW'(ADR_CMP0 + 2 * i)))
                cmp[i] <= wdata[CW-1:0];
        end
    end

    // sticky flags: a match in the same cycle beats a clearing write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag <= '0;
        else
            flag <= (wr_flag ? (flag & wdata[NCH-1:0]) : flag) | hit;
    end

    always_comb begin
        rdata = '0;
        if (addr == AW'(ADR_CTRL))  rdata = DW'(ctrl);
        if (addr == AW'(ADR_COUNT)) rdata = DW'(cnt);
        if (addr == AW'(ADR_ACT))   rdata = DW'(code);
        if (addr == AW'(ADR_FLAG))  rdata = DW'(flag);
        if (addr == AW'(ADR_PINS)) begin
            for (int i = 0; i < NCH; i++) begin
                rdata[i]           = init[i];
                rdata[DIS_LSB + i] = dis[i];
            end
        end
        for (int i = 0; i < NCH; i++)
            if (addr == AW'(ADR_CMP0 + 2 * i)) rdata = DW'(cmp[i]);
    end

    // R8: without a flag write, no flag drops
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_flag |=> ((flag & $past(flag)) == $past(flag)));

    // R8: a match always leaves its flag set, clearing write or not
    p_match_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> ((flag & $past(hit)) == $past(hit)));
endmodule

// File: rtl/tc_counter.sv
module tc_counter import tmr_cmp3_pkg::*; #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  ctrl_t         ctrl,
    input  logic          cnt_wr,
    input  logic [CW-1:0] cnt_wval,
    input  logic          hit_a,
    output logic          en,
    output logic [CW-1:0] cnt_q,
    output run_e          state_q
);
    run_e state_d;
    logic clr;

    assign en  = tick && ctrl.start && (state_q != ST_HALT) && !cnt_wr;
    assign clr = hit_a && (ctrl.clr_sel == CLR_ON_A);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ctrl.start)
                         state_d = (hit_a && !ctrl.cont) ? ST_HALT : ST_RUN;   // go / stop_on_a
            ST_RUN:  if (!ctrl.start)
                         state_d = ST_IDLE;                                    // pause
                     else if (hit_a && !ctrl.cont)
                         state_d = ST_HALT;                                    // stop_on_a
            ST_HALT: if (!ctrl.start)
                         state_d = ST_IDLE;                                    // release
            default: state_d = ST_IDLE;
        endcase
    end

    // counter output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_wr) cnt_q <= cnt_wval;
        else if (en)     cnt_q <= clr ? '0 : cnt_q + 1'b1;
    end

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr) |=> (cnt_q == $past(cnt_q) + 1'b1));

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && hit_a && ctrl.clr_sel == CLR_ON_A) |=> (cnt_q == '0));

    p_halt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !cnt_wr) |=> $stable(cnt_q));

    p_stopped_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.start && !cnt_wr) |=> $stable(cnt_q));
endmodule

// File: rtl/tc_chan.sv
module tc_chan import tmr_cmp3_pkg::*; #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          load,
    input  logic          init,
    input  act_e          act,
    input  logic [CW-1:0] cmp,
    input  logic [CW-1:0] cnt,
    output logic          hit,
    output logic          out_q
);
    assign hit = en && (cnt == cmp);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            out_q <= 1'b0;
        else if (load)
            out_q <= init;
        else if (hit) begin
            unique case (act)
                ACT_KEEP: out_q <= out_q;
                ACT_LOW:  out_q <= 1'b0;
                ACT_HIGH: out_q <= 1'b1;
                ACT_FLIP: out_q <= ~out_q;
                default:  out_q <= out_q;
            endcase
        end
    end

    p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !load) |=> $stable(out_q));

    p_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !load && act == ACT_FLIP) |=> (out_q != $past(out_q)));
endmodule

// File: rtl/tmr_cmp3.sv
module tmr_cmp3 import tmr_cmp3_pkg::*; #(
    parameter int AW  = 8,
    parameter int DW  = 16,
    parameter int CW  = 16,
    parameter int NCH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           wr_en,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata,
    output logic [NCH-1:0] pin_o,
    output logic [NCH-1:0] flag_o
);
    ctrl_t                      ctrl;
    logic [NCH-1:0][CW-1:0]     cmp;
    logic [NCH-1:0][CODE_W-1:0] code;
    logic [NCH-1:0]             init, dis, hit, outs;
    logic                       cnt_wr, en;
    logic [CW-1:0]              cnt_wval, cnt;
    run_e                       state;

    tc_regs #(.AW(AW), .DW(DW), .CW(CW), .NCH(NCH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .hit(hit), .cnt(cnt), .ctrl(ctrl), .cmp(cmp), .code(code),
        .init(init), .dis(dis), .flag(flag_o), .cnt_wr(cnt_wr),
        .cnt_wval(cnt_wval), .rdata(rdata)
    );

    tc_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl(ctrl), .cnt_wr(cnt_wr),
        .cnt_wval(cnt_wval), .hit_a(hit[0]), .en(en), .cnt_q(cnt),
        .state_q(state)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        tc_chan #(.CW(CW)) u_ch (
            .clk(clk), .rst_n(rst_n), .en(en), .load(cnt_wr), .init(init[i]),
            .act(act_e'(code[i][1:0])), .cmp(cmp[i]), .cnt(cnt),
            .hit(hit[i]), .out_q(outs[i])
        );
    end

    assign pin_o = outs & ~dis;

    // R4: in HALT no channel sees a match
    p_halt_no_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |-> (hit == '0));
endmodule

// File: tb/sim_tmr_cmp3.sv
module sim_tmr_cmp3;
    localparam logic [7:0] A_CTRL = 8'h00, A_CNT = 8'h02, A_CA = 8'h04,
                           A_CB = 8'h06, A_CC = 8'h08, A_ACT = 8'h0A,
                           A_PIN = 8'h0C, A_FLG = 8'h0E;

    logic clk = 0, rst_n = 0, tick = 0, wr_en = 0;
    logic [7:0]  addr = 0;
    logic [15:0] wdata = 0;
    logic [15:0] rdata;
    logic [2:0]  pin_o, flag_o;

    int nchk = 0, nbad = 0;
    string tag = "R1";

    // reference model state
    logic        m_start, m_cont, m_halt;
    logic [2:0]  m_clr, m_init, m_dis, m_flag, m_out;
    logic [15:0] m_cnt;
    logic [15:0] m_cmp [3];
    logic [3:0]  m_code [3];

    always #2 clk = ~clk;

    tmr_cmp3 u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
                 .addr(addr), .wdata(wdata), .rdata(rdata), .pin_o(pin_o),
                 .flag_o(flag_o));

    task automatic chk(string what, logic [15:0] got, logic [15:0] exp);
        nchk++;
        if (got !== exp) begin
            nbad++;
            $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
        end
    endtask

    function automatic logic act_out(logic [3:0] c, logic cur);
        case (c[1:0])
            2'b01:   return 1'b0;
            2'b10:   return 1'b1;
            2'b11:   return ~cur;
            default: return cur;
        endcase
    endfunction

    task automatic model_reset();
        m_start = 0; m_cont = 0; m_halt = 0; m_clr = 0; m_init = 0;
        m_dis = 0; m_flag = 0; m_out = 0; m_cnt = 0;
        for (int i = 0; i < 3; i++) begin m_cmp[i] = 16'hFFFF; m_code[i] = 0; end
    endtask

    task automatic model(bit wr, logic [7:0] a, logic [15:0] d, bit tk);
        bit cw, en;
        logic [2:0] h;
        cw = wr && a == A_CNT;
        en = tk && m_start && !m_halt && !cw;
        for (int i = 0; i < 3; i++) h[i] = en && (m_cnt == m_cmp[i]);
        m_flag = ((wr && a == A_FLG) ? (m_flag & d[2:0]) : m_flag) | h;
        for (int i = 0; i < 3; i++)
            m_out[i] = cw ? m_init[i] : (h[i] ? act_out(m_code[i], m_out[i]) : m_out[i]);
        if (!m_start) m_halt = 0;
        else if (h[0] && !m_cont) m_halt = 1;
        if (cw) m_cnt = d;
        else if (en) m_cnt = (h[0] && m_clr == 3'b001) ? 16'h0 : m_cnt + 16'h1;
        if (wr) begin
            case (a)
                A_CTRL: begin m_start = d[0]; m_cont = d[1]; m_clr = d[4:2]; end
                A_CA:   m_cmp[0] = d;
                A_CB:   m_cmp[1] = d;
                A_CC:   m_cmp[2] = d;
                A_ACT:  begin m_code[0] = d[3:0]; m_code[1] = d[7:4]; m_code[2] = d[11:8]; end
                A_PIN:  begin m_init = d[2:0]; m_dis = d[6:4]; end
                default: ;
            endcase
        end
    endtask

    task automatic step(bit wr, logic [7:0] a, logic [15:0] d, bit tk);
        @(negedge clk);
        wr_en = wr; addr = wr ? a : A_CNT; wdata = d; tick = tk;
        #1;
        if (!wr) chk("count", rdata, m_cnt);
        model(wr, a, d, tk);
        @(posedge clk); #1;
        chk("pins", {13'd0, pin_o}, {13'd0, m_out & ~m_dis});
        chk("flags", {13'd0, flag_o}, {13'd0, m_flag});
    endtask

    task automatic rd(logic [7:0] a, logic [15:0] exp);
        @(negedge clk);
        wr_en = 0; addr = a; tick = 0;
        #1; chk("read", rdata, exp);
        model(0, a, 0, 0);
    endtask

    task automatic run(int n);
        for (int k = 0; k < n; k++) step(0, 0, 0, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R1 reset state
        tag = "R1";
        #1;
        chk("pins", {13'd0, pin_o}, 16'h0);
        chk("flags", {13'd0, flag_o}, 16'h0);
        rd(A_CNT, 16'h0); rd(A_CA, 16'hFFFF); rd(A_CC, 16'hFFFF);
        rd(A_CTRL, 16'h0); rd(A_ACT, 16'h0); rd(A_PIN, 16'h0);

        // R10 readback
        tag = "R10";
        step(1, A_CA, 16'h1234, 0); step(1, A_ACT, 16'hF93B, 0);
        step(1, A_PIN, 16'hFFFF, 0); step(1, A_CTRL, 16'hFFFE, 0);
        rd(A_CA, 16'h1234); rd(A_ACT, 16'h093B); rd(A_PIN, 16'h0077);
        rd(A_CTRL, 16'h001E);

        // R6 / R7 / R3: clear on A, invert A, high B, low C, C starts high
        tag = "R7";
        step(1, A_PIN, 16'h0004, 0);
        step(1, A_CA, 16'd5, 0); step(1, A_CB, 16'd2, 0); step(1, A_CC, 16'd3, 0);
        step(1, A_ACT, 16'h0923, 0);
        step(1, A_CNT, 16'd0, 1);
        chk("init levels", {13'd0, pin_o}, 16'h0004);
        tag = "R3";
        step(1, A_CTRL, 16'h0007, 0);
        run(8);
        tag = "R6";
        run(12);

        // R4 stop after A match, then resume
        tag = "R4";
        step(1, A_CTRL, 16'h0005, 0);
        run(12);
        chk("halt count", m_cnt, m_cnt);
        step(1, A_CTRL, 16'h0004, 1);
        step(1, A_CTRL, 16'h0005, 1);
        run(3);

        // R5 start cleared holds everything
        tag = "R5";
        step(1, A_CTRL, 16'h0006, 1);
        run(10);
        step(1, A_CTRL, 16'h0007, 0);
        run(4);

        // R11 wrap
        tag = "R11";
        step(1, A_CTRL, 16'h0003, 0);
        step(1, A_CNT, 16'hFFFE, 0);
        run(3);
        rd(A_CNT, 16'h0001);

        // R8 flags: write 1 keeps, write 0 clears, match beats clear
        tag = "R8";
        step(1, A_FLG, 16'h0007, 0);
        step(1, A_FLG, 16'h0000, 0);
        step(1, A_CTRL, 16'h0007, 0);
        step(1, A_CNT, 16'd2, 0);
        step(1, A_FLG, 16'h0000, 1);
        chk("B flag held", {15'd0, flag_o[1]}, 16'h1);

        // R9 disables
        tag = "R9";
        step(1, A_CNT, 16'd0, 0);
        step(1, A_PIN, 16'h0075, 0);
        run(6);
        step(1, A_PIN, 16'h0005, 0);
        run(6);

        // random traffic, R2 and R6 rules throughout
        tag = "R2";
        for (int k = 0; k < 4000; k++) begin
            int r;
            r = int'($urandom % 16);
            if (r == 0) begin
                logic [7:0] a;
                logic [15:0] d;
                case ($urandom % 8)
                    0: begin a = A_CTRL; d = {11'd0, ($urandom % 2) ? 3'b001 : 3'b000,
                                              1'($urandom), ($urandom % 5) != 0}; end
                    1: begin a = A_CNT;  d = 16'($urandom % 12); end
                    2: begin a = A_CA;   d = 16'($urandom % 12); end
                    3: begin a = A_CB;   d = 16'($urandom % 12); end
                    4: begin a = A_CC;   d = 16'($urandom % 12); end
                    5: begin a = A_ACT;  d = 16'($urandom); end
                    6: begin a = A_PIN;  d = 16'($urandom); end
                    default: begin a = A_FLG; d = 16'($urandom); end
                endcase
                step(1, a, d, 1'($urandom));
            end else
                step(0, 0, 0, r > 4);
        end

        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule